// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block is the device-side ownership logic behind a security module's byte-wide, memory-mapped register window. The window is divided into localities, and each locality has its own copy of a one-byte access register at offset zero. Software claims a locality by writing a request bit. It then polls that byte until the valid and active bits read as one. It hands the locality back by writing the active bit. A higher locality can take ownership by force, and the locality that loses it sees a seized flag.

The block keeps the current owner, a pending-request flag for each fully supported locality, and a seized flag for each. It also gates every other offset of the register window so that only the owning locality reaches the downstream register file. Localities above the fully supported range are stubs. When ownership changes, the block gives a one-cycle event that the interrupt logic can latch as a locality-change cause.

Top module: `loc_access_ctrl`

## Requirements
- R1: After reset there is no owner, no locality has a pending request, `loc_chg_evt` is 0, and the access byte of locality 0 reads 0x80.
- R2: If locality 0 writes bit1 (request) while there is no owner, it becomes the owner on the second clock edge after the write. From then on its access byte reads 0xA0: bit7 is valid and bit5 is active.
- R3: For exactly one cycle after an accepted request write or an accepted seize write, bit7 (valid) of every access byte reads 0. During that cycle the requester's own bit1 reads 1 while its request is still outstanding.
- R4: If the owner writes bit5, it releases ownership at that clock edge, and the next read shows `owner_vld` = 0.
- R5: A request made while another locality owns the block stays pending. The requester reads bit1 = 1, and every other locality reads bit2 = 1. The grant comes one edge after the owner releases.
- R6: If several requests are pending when the block is free, the highest-numbered locality is granted.
- R7: If a supported locality with a higher number than the owner writes bit3 (seize), it becomes the owner at that edge. The previous owner then reads bit4 (seized) = 1 until it writes 1 to bit4.
- R8: A seize write from a locality whose number is equal to or lower than the owner's has no effect.
- R9: `loc_chg_evt` is high for exactly the one cycle that follows each edge where the owner changes (grant, release or seize).
- R10: At offsets other than zero, the owner reads `rf_rdata` and its writes assert `rf_wr`. Any other locality reads 0xFF and gets no `rf_wr`, and the same holds when there is no owner.
- R11: The stub localities (FULL_LOC up to NUM_LOC-1) read their access byte as 0x80 when valid is set, and writes from them change nothing. Locality numbers at or above NUM_LOC read 0xFF.
- R12: A release write from a locality that does not own the block is ignored. So is a request write from the owner. Neither one clears valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_loc | input | LOC_W | Locality number of the current access |
| bus_off | input | OFF_W | Register offset within the locality |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access (combinational) |
| rf_rdata | input | 8 | Read data from the downstream register file |
| rf_wr | output | 1 | Write strobe passed to the register file, owner only |
| owner_vld | output | 1 | Some locality owns the block |
| owner_loc | output | LOC_W | Number of the owning locality |
| loc_chg_evt | output | 1 | One-cycle pulse after an ownership change |

## Verification
The assertions assume that the bus carries at most one write per cycle and that `bus_loc` and `bus_off` stay steady for the whole cycle. The bench meets this by changing every input only on the falling clock edge and by driving a single access at a time. The grant-bound and seize properties also assume that only supported localities can become owner. The stimulus sends seize and request writes from stub localities only to confirm that they are ignored, so this assumption holds throughout.

// File: rtl/loc_pkg.sv
package loc_pkg;
  localparam int ACC_VALID      = 7;
  localparam int ACC_ACTIVE     = 5;
  localparam int ACC_SEIZED     = 4;
  localparam int ACC_SEIZE      = 3;
  localparam int ACC_OTHER_PEND = 2;
  localparam int ACC_REQ        = 1;

  // Build the access byte seen by one locality.
  function automatic logic [7:0] pack_access(input logic valid, input logic active,
                                             input logic seized, input logic other_pend,
                                             input logic own_pend);
    logic [7:0] b;
    b = 8'h00;
    b[ACC_VALID]      = valid;
    b[ACC_ACTIVE]     = active;
    b[ACC_SEIZED]     = seized;
    b[ACC_OTHER_PEND] = other_pend;
    b[ACC_REQ]        = own_pend;
    return b;
  endfunction
endpackage

// File: rtl/loc_slot.sv
module loc_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic lost,
  input  logic clr_seized,
  output logic pend,
  output logic seized
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      seized <= 1'b0;
    end else begin
      if (clr_req)      pend <= 1'b0;
      else if (set_req) pend <= 1'b1;
      if (lost)            seized <= 1'b1;
      else if (clr_seized) seized <= 1'b0;
    end
  end

  assert_lost_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> seized);
  assert_grant_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !pend);
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter #(
  parameter int N     = 3,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     pend,
  output logic             pick_vld,
  output logic [IDX_W-1:0] pick_idx
);
  // Highest set index wins.
  function automatic logic [IDX_W-1:0] top_index(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign pick_vld = |pend;
  assign pick_idx = top_index(pend);
endmodule

// File: rtl/loc_gate.sv
module loc_gate (
  input  logic       is_acc,
  input  logic       loc_full,
  input  logic       loc_exists,
  input  logic       own,
  input  logic       bus_wr,
  input  logic       valid_bit,
  input  logic [7:0] acc_byte,
  input  logic [7:0] rf_rdata,
  output logic [7:0] rdata,
  output logic       rf_wr
);
  always_comb begin
    if (!loc_exists)   rdata = 8'hFF;
    else if (is_acc)   rdata = loc_full ? acc_byte : {valid_bit, 7'b0};
    else if (own)      rdata = rf_rdata;
    else               rdata = 8'hFF;
  end

  assign rf_wr = bus_wr && !is_acc && own && loc_exists;
endmodule

// File: rtl/loc_access_ctrl.sv
module loc_access_ctrl #(
  parameter int NUM_LOC  = 5,
  parameter int FULL_LOC = 3,
  parameter int OFF_W    = 12,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] bus_loc,
  input  logic [OFF_W-1:0] bus_off,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [7:0]       rf_rdata,
  output logic             rf_wr,
  output logic             owner_vld,
  output logic [LOC_W-1:0] owner_loc,
  output logic             loc_chg_evt
);
  import loc_pkg::*;

  logic               owner_vld_q, settle_q, evt_q;
  logic [LOC_W-1:0]   owner_q;
  logic [FULL_LOC-1:0] pend, seized, reader_mask;
  logic               pick_vld;
  logic [LOC_W-1:0]   pick_idx;

  // Decode of the current access.
  logic off_zero, loc_full, loc_exists, wr_acc, is_own;
  assign off_zero   = (bus_off == '0);
  assign loc_full   = ({1'b0, bus_loc} < (LOC_W+1)'(FULL_LOC));
  assign loc_exists = ({1'b0, bus_loc} < (LOC_W+1)'(NUM_LOC));
  assign wr_acc     = bus_wr && off_zero && loc_full;
  assign is_own     = owner_vld_q && (owner_q == bus_loc);

  // Internal events, named for the assertions.
  logic do_rel, do_seize, do_req, do_grant;
  assign do_rel   = wr_acc && bus_wdata[ACC_ACTIVE] && is_own;
  assign do_seize = wr_acc && bus_wdata[ACC_SEIZE] && owner_vld_q && (bus_loc > owner_q);
  assign do_req   = wr_acc && bus_wdata[ACC_REQ] && !is_own;
  assign do_grant = !owner_vld_q && pick_vld;

  loc_arbiter #(.N(FULL_LOC), .IDX_W(LOC_W)) u_arb (
    .pend(pend), .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  for (genvar g = 0; g < FULL_LOC; g++) begin : g_slot
    logic sel;
    assign sel = (bus_loc == LOC_W'(g));
    assign reader_mask[g] = sel;
    loc_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .set_req(do_req && sel),
      .clr_req((do_grant && pick_idx == LOC_W'(g)) || (do_seize && sel)),
      .lost(do_seize && owner_q == LOC_W'(g)),
      .clr_seized(wr_acc && sel && bus_wdata[ACC_SEIZED]),
      .pend(pend[g]), .seized(seized[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_vld_q <= 1'b0;
      owner_q     <= '0;
      settle_q    <= 1'b0;
      evt_q       <= 1'b0;
    end else begin
      if (do_rel) begin
        owner_vld_q <= 1'b0;
      end else if (do_seize) begin
        owner_q <= bus_loc;
      end else if (do_grant) begin
        owner_vld_q <= 1'b1;
        owner_q     <= pick_idx;
      end
      settle_q <= do_req || do_seize;
      evt_q    <= do_rel || do_seize || do_grant;
    end
  end

  logic [7:0] acc_byte;
  assign acc_byte = pack_access(!settle_q, is_own, |(seized & reader_mask),
                                |(pend & ~reader_mask), |(pend & reader_mask));

  loc_gate u_gate (
    .is_acc(off_zero), .loc_full(loc_full), .loc_exists(loc_exists), .own(is_own),
    .bus_wr(bus_wr), .valid_bit(!settle_q), .acc_byte(acc_byte), .rf_rdata(rf_rdata),
    .rdata(bus_rdata), .rf_wr(rf_wr)
  );

  assign owner_vld   = owner_vld_q;
  assign owner_loc   = owner_q;
  assign loc_chg_evt = evt_q;

  assert_grant_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!owner_vld_q && |pend) |=> owner_vld_q);
  assert_valid_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    settle_q |-> $past(do_req || do_seize));
  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_rel |=> !owner_vld_q);
  assert_seize_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_seize |=> (owner_vld_q && owner_q == $past(bus_loc)));
  assert_low_seize_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && bus_wdata[ACC_SEIZE] && !bus_wdata[ACC_ACTIVE] && owner_vld_q && bus_loc <= owner_q)
      |=> (owner_vld_q && $stable(owner_q)));
  assert_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({owner_vld_q, owner_q}) |-> loc_chg_evt);
  assert_owner_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (owner_vld_q && owner_q == bus_loc));
endmodule

// File: tb/test_loc_access_ctrl.sv
module test_loc_access_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_loc = '0;
  logic [11:0] bus_off = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] rf_rdata = 8'h3C;
  logic       rf_wr, owner_vld, loc_chg_evt;
  logic [2:0] owner_loc;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  loc_access_ctrl i_loc_access_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_loc(bus_loc), .bus_off(bus_off), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rf_rdata(rf_rdata), .rf_wr(rf_wr),
    .owner_vld(owner_vld), .owner_loc(owner_loc), .loc_chg_evt(loc_chg_evt)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {loc, off, wr, wdata, expected read, requirement number}
  localparam int NV = 30;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 12'h000, 1'b0, 8'h00, 8'h80, 4'd1},  // R1 idle
    {3'd0, 12'h004, 1'b0, 8'h00, 8'hFF, 4'd10}, // R10 no owner
    {3'd0, 12'h000, 1'b1, 8'h02, 8'h80, 4'd2},  // R2 request
    {3'd0, 12'h000, 1'b0, 8'h00, 8'h02, 4'd3},  // R3 resolving
    {3'd0, 12'h000, 1'b0, 8'h00, 8'hA0, 4'd2},  // R2 granted
    {3'd0, 12'h004, 1'b0, 8'h00, 8'h3C, 4'd10}, // R10 owner read
    {3'd1, 12'h004, 1'b0, 8'h00, 8'hFF, 4'd10}, // R10 non-owner
    {3'd1, 12'h000, 1'b1, 8'h02, 8'h80, 4'd5},  // R5 request while busy
    {3'd1, 12'h000, 1'b0, 8'h00, 8'h02, 4'd3},  // R3
    {3'd1, 12'h000, 1'b0, 8'h00, 8'h82, 4'd5},  // R5 own pending
    {3'd0, 12'h000, 1'b0, 8'h00, 8'hA4, 4'd5},  // R5 other pending
    {3'd0, 12'h000, 1'b1, 8'h20, 8'hA4, 4'd4},  // R4 release
    {3'd1, 12'h000, 1'b0, 8'h00, 8'h82, 4'd5},  // R5 free, grant here
    {3'd1, 12'h000, 1'b0, 8'h00, 8'hA0, 4'd5},  // R5 granted
    {3'd2, 12'h000, 1'b1, 8'h08, 8'h80, 4'd7},  // R7 seize
    {3'd2, 12'h000, 1'b0, 8'h00, 8'h20, 4'd3},  // R3 after seize
    {3'd2, 12'h000, 1'b0, 8'h00, 8'hA0, 4'd7},  // R7 new owner
    {3'd1, 12'h000, 1'b0, 8'h00, 8'h90, 4'd7},  // R7 seized flag
    {3'd1, 12'h000, 1'b1, 8'h10, 8'h90, 4'd7},  // R7 clear flag
    {3'd1, 12'h000, 1'b0, 8'h00, 8'h80, 4'd7},  // R7 cleared
    {3'd1, 12'h000, 1'b1, 8'h08, 8'h80, 4'd8},  // R8 low seize
    {3'd1, 12'h000, 1'b0, 8'h00, 8'h80, 4'd8},  // R8 no settle
    {3'd2, 12'h000, 1'b0, 8'h00, 8'hA0, 4'd8},  // R8 owner kept
    {3'd3, 12'h000, 1'b1, 8'h02, 8'h80, 4'd11}, // R11 stub write
    {3'd3, 12'h000, 1'b0, 8'h00, 8'h80, 4'd11}, // R11 stub read
    {3'd5, 12'h000, 1'b0, 8'h00, 8'hFF, 4'd11}, // R11 out of range
    {3'd1, 12'h000, 1'b1, 8'h20, 8'h80, 4'd12}, // R12 foreign release
    {3'd2, 12'h000, 1'b0, 8'h00, 8'hA0, 4'd12}, // R12 owner kept
    {3'd2, 12'h000, 1'b1, 8'h02, 8'hA0, 4'd12}, // R12 owner request
    {3'd2, 12'h000, 1'b0, 8'h00, 8'hA0, 4'd12}  // R12 valid stays
  };

  task automatic drive(input logic [2:0] l, input logic [11:0] o, input logic w, input logic [7:0] d);
    @(negedge clk);
    bus_loc = l; bus_off = o; bus_wr = w; bus_wdata = d;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 owner_vld", {7'b0, owner_vld}, 8'h00);
    check("R1 evt", {7'b0, loc_chg_evt}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35:33], VEC[i][32:21], VEC[i][20], VEC[i][19:12]);
      check($sformatf("R%0d step %0d", VEC[i][3:0], i), bus_rdata, VEC[i][11:4]);
    end
    // R6 / R9: two pending requests under owner 2, then release.
    drive(3'd0, 12'h000, 1'b1, 8'h02);
    drive(3'd1, 12'h000, 1'b1, 8'h02);
    drive(3'd2, 12'h000, 1'b1, 8'h20);
    drive(3'd0, 12'h000, 1'b0, 8'h00);
    check("R4 released", {7'b0, owner_vld}, 8'h00);
    check("R9 release pulse", {7'b0, loc_chg_evt}, 8'h01);
    drive(3'd0, 12'h000, 1'b0, 8'h00);
    check("R6 owner valid", {7'b0, owner_vld}, 8'h01);
    check("R6 highest wins", {5'b0, owner_loc}, 8'h01);
    check("R9 grant pulse", {7'b0, loc_chg_evt}, 8'h01);
    drive(3'd0, 12'h000, 1'b0, 8'h00);
    check("R9 pulse ends", {7'b0, loc_chg_evt}, 8'h00);
    check("R5 loser pending", bus_rdata, 8'h82);
    // R10 write gating.
    drive(3'd1, 12'h004, 1'b1, 8'h55);
    check("R10 owner write", {7'b0, rf_wr}, 8'h01);
    drive(3'd0, 12'h004, 1'b1, 8'h55);
    check("R10 blocked write", {7'b0, rf_wr}, 8'h00);
    drive(3'd0, 12'h000, 1'b0, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule